// File: doc/BRIEF.md
# Numerically Controlled Oscillator Core

This block is the digital heart of a direct digital synthesizer. A 32-bit phase accumulator grows by a frequency tuning word on every system clock, so the output frequency is the tuning word times the clock frequency divided by 2^32. At a 180 MHz clock one tuning-word step is roughly 0.04 Hz. A 5-bit phase offset, counted in steps of 1/32 of a turn (11.25 degrees), is added to the top of the accumulated phase. The sum addresses a quarter-wave sine table, and the result leaves the block as an unsigned 10-bit converter code. A square wave taken from the top bit of the offset phase is also provided.

Software or a host controller places a new tuning word, phase word and sleep flag on the inputs and pulses a load strobe. All three fields are captured together, so the generator never runs on a word that is only half updated. In sleep the phase stops where it is and the converter code rests at mid-scale.

Top module: `nco_core`

## Requirements
- R1: While rst is high and on the first cycle after it, dac_code is 512 and sq_out is 0; the accumulator, tuning word, phase word and sleep flag are all zero.
- R2: On each rising clock edge with sleep inactive, the accumulator adds the active tuning word modulo 2^32; with tuning word 0x1000_0000 the square output has a period of exactly 16 clocks.
- R3: ftw_in, pow_in and pdn_in are copied into the active set together at the edge where load is high and are used from the next edge on; while load is low their values have no effect on the outputs.
- R4: The phase word is added to accumulator bits [31:27] (one step per 1/32 turn) before the lookup, and the accumulator itself is never changed by it; with a zero accumulator phase words 8, 16 and 24 give codes 1023, 511 and 0.
- R5: For a 12-bit offset phase p (top 12 bits of accumulator plus offset), the code is 512 + round(511·s) when s = sin(2π(p+0.5)/4096) is non-negative and 511 − round(−511·s) when negative.
- R6: dac_code and sq_out are registered: the value present after edge k is computed from the accumulator and active set held just before edge k.
- R7: sq_out equals bit 11 of the offset phase, so it is 1 exactly when dac_code is below 512.
- R8: While the sleep flag is active the accumulator holds its value, dac_code is 512 and sq_out is 0; on leaving sleep the waveform continues from the held phase.
- R9: The accumulator wraps modulo 2^32, so a tuning word of 0xFFFF_FFFF steps the phase backwards by one count per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | Capture strobe for the three control fields |
| ftw_in | input | 32 | Frequency tuning word to load |
| pow_in | input | 5 | Phase offset word to load, 1/32 turn per step |
| pdn_in | input | 1 | Sleep flag to load, 1 = sleep |
| dac_code | output | 10 | Unsigned sine code for the converter |
| sq_out | output | 1 | Square wave, top bit of the offset phase |

## Verification
A load seen at edge N changes the active set at N, the accumulator first moves by the new word at N+1, and the code reflecting a new phase word appears after N+1; so a fresh phase word shows two edges after the load, while a new tuning word first bends the waveform after N+2. The bench keeps a behavioural model that follows this register order and compares both outputs at every falling edge, which keeps each comparison aligned to the exact cycle its result is due. Fixed-value checks at the quadrant points, a square-wave period count and a sleep/wake sequence add named checks for the boundary cases.

// File: rtl/nco_pkg.sv
package nco_pkg;

    localparam int ACC_W  = 32;
    localparam int PHW_W  = 5;
    localparam int DAC_W  = 10;
    localparam int LUT_IN_W = 12;

    typedef struct packed {
        logic [ACC_W-1:0] ftw;
        logic [PHW_W-1:0] pow;
        logic             pdn;
    } nco_cfg_t;

    // Offset phase: top bits of the accumulator plus the phase word aligned to the MSB
    function automatic logic [LUT_IN_W-1:0] offset_phase(
        input logic [ACC_W-1:0] acc,
        input logic [PHW_W-1:0] pow
    );
        logic [LUT_IN_W-1:0] aligned;
        aligned = {pow, {(LUT_IN_W-PHW_W){1'b0}}};
        return acc[ACC_W-1 -: LUT_IN_W] + aligned;
    endfunction

endpackage

// File: rtl/nco_ctrl_regs.sv
module nco_ctrl_regs
    import nco_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     upd_i,
    input  nco_cfg_t cfg_i,
    output nco_cfg_t cfg_o
);

    nco_cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (upd_i) begin
            cfg_q <= cfg_i;
        end
    end

    assign cfg_o = cfg_q;

    // R3
    cfg_capture_chk: assert property (@(posedge clk) disable iff (rst)
        upd_i |=> (cfg_o == $past(cfg_i)));

    // R3
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !upd_i |=> $stable(cfg_o));

endmodule

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
    parameter int W = nco_pkg::ACC_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] ftw_i,
    input  logic         pd_i,
    output logic [W-1:0] acc_o
);

    logic [W-1:0] acc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else if (!pd_i) begin
            acc_q <= acc_q + ftw_i;
        end
    end

    assign acc_o = acc_q;

    // R8
    acc_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        pd_i |=> $stable(acc_o));

    // R2
    acc_step_chk: assert property (@(posedge clk) disable iff (rst)
        !pd_i |=> (acc_o - $past(acc_o)) == $past(ftw_i));

endmodule

// File: rtl/nco_sine_lut.sv
module nco_sine_lut #(
    parameter int IN_W  = nco_pkg::LUT_IN_W,
    parameter int OUT_W = nco_pkg::DAC_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IN_W-1:0]  phase_i,
    input  logic             pd_i,
    output logic [OUT_W-1:0] code_o,
    output logic             sq_o
);

    localparam int AW    = IN_W - 2;
    localparam int DEPTH = 1 << AW;
    localparam int MW    = OUT_W - 1;
    localparam int AMP   = (1 << MW) - 1;
    localparam logic [OUT_W-1:0] MID = OUT_W'(1 << MW);
    localparam real TWO_PI = 6.283185307179586;

    logic [MW-1:0] quarter_rom [DEPTH];

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            quarter_rom[i] = MW'($rtoi(real'(AMP) *
                $sin(TWO_PI * (real'(i) + 0.5) / real'(4 * DEPTH)) + 0.5));
        end
    end

    logic [1:0]       quad;
    logic [AW-1:0]    addr;
    logic [MW-1:0]    mag;
    logic [OUT_W-1:0] val;

    always_comb begin
        quad = phase_i[IN_W-1 -: 2];
        addr = quad[0] ? ~phase_i[AW-1:0] : phase_i[AW-1:0];
        mag  = quarter_rom[addr];
        if (quad[1]) begin
            val = MID - OUT_W'(1) - OUT_W'(mag);
        end else begin
            val = MID + OUT_W'(mag);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            code_o <= MID;
            sq_o   <= 1'b0;
        end else if (pd_i) begin
            code_o <= MID;
            sq_o   <= 1'b0;
        end else begin
            code_o <= val;
            sq_o   <= phase_i[IN_W-1];
        end
    end

    // R8
    sleep_mid_chk: assert property (@(posedge clk) disable iff (rst)
        pd_i |=> (code_o == MID) && !sq_o);

    // R7
    sq_half_chk: assert property (@(posedge clk) disable iff (rst)
        !pd_i |=> (sq_o == (code_o < MID)));

endmodule

// File: rtl/nco_core.sv
module nco_core
    import nco_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [ACC_W-1:0] ftw_in,
    input  logic [PHW_W-1:0] pow_in,
    input  logic             pdn_in,
    output logic [DAC_W-1:0] dac_code,
    output logic             sq_out
);

    nco_cfg_t            cfg_new;
    nco_cfg_t            cfg_act;
    logic [ACC_W-1:0]    acc;
    logic [LUT_IN_W-1:0] phase;

    assign cfg_new = '{ftw: ftw_in, pow: pow_in, pdn: pdn_in};

    nco_ctrl_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .upd_i (load),
        .cfg_i (cfg_new),
        .cfg_o (cfg_act)
    );

    nco_phase_acc #(.W(ACC_W)) u_acc (
        .clk   (clk),
        .rst   (rst),
        .ftw_i (cfg_act.ftw),
        .pd_i  (cfg_act.pdn),
        .acc_o (acc)
    );

    assign phase = offset_phase(acc, cfg_act.pow);

    nco_sine_lut #(.IN_W(LUT_IN_W), .OUT_W(DAC_W)) u_lut (
        .clk     (clk),
        .rst     (rst),
        .phase_i (phase),
        .pd_i    (cfg_act.pdn),
        .code_o  (dac_code),
        .sq_o    (sq_out)
    );

    // R4
    pow_top_bits_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_act.pow == '0) |-> (phase == acc[ACC_W-1 -: LUT_IN_W]));

endmodule

// File: tb/nco_core_bench.sv
module nco_core_bench;

    localparam int CLK_PERIOD = 10;
    localparam real TWO_PI = 6.283185307179586;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        load = 1'b0;
    logic [31:0] ftw_in = '0;
    logic [4:0]  pow_in = '0;
    logic        pdn_in = 1'b0;
    logic [9:0]  dac_code;
    logic        sq_out;

    int checks = 0;
    int errors = 0;
    string tag = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    nco_core u_nco_core (
        .clk(clk), .rst(rst), .load(load), .ftw_in(ftw_in),
        .pow_in(pow_in), .pdn_in(pdn_in), .dac_code(dac_code), .sq_out(sq_out)
    );

    // Behavioural reference state
    bit [31:0] m_acc = 0;
    bit [31:0] m_ftw = 0;
    int        m_pow = 0;
    bit        m_pdn = 0;
    int        m_code = 512;
    bit        m_sq = 0;

    function automatic int sine_code(int p);
        real s;
        s = $sin(TWO_PI * (real'(p) + 0.5) / 4096.0);
        if (s >= 0.0) return 512 + $rtoi(511.0 * s + 0.5);
        else          return 511 - $rtoi(-511.0 * s + 0.5);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_acc = 0; m_ftw = 0; m_pow = 0; m_pdn = 0;
            m_code = 512; m_sq = 0;
        end else begin
            int p;
            p = (int'(m_acc / 32'd1048576) + m_pow * 128) % 4096;
            if (m_pdn) begin
                m_code = 512; m_sq = 0;
            end else begin
                m_code = sine_code(p);
                m_sq = (p >= 2048);
            end
            if (!m_pdn) m_acc = m_acc + m_ftw;
            if (load) begin
                m_ftw = ftw_in; m_pow = int'(pow_in); m_pdn = pdn_in;
            end
        end
    end

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Called at the falling edge: compare against the model every clock
    task automatic step();
        @(negedge clk);
        check(tag, int'(dac_code), m_code);
        check(tag, int'(sq_out), int'(m_sq));
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic do_load(logic [31:0] f, logic [4:0] w, logic pd);
        ftw_in = f; pow_in = w; pdn_in = pd; load = 1'b1;
        step();
        load = 1'b0;
    endtask

    initial begin
        int rises;
        bit prev;
        bit [31:0] held;

        // R1 reset state
        tag = "R1";
        repeat (3) @(negedge clk);
        check("R1", int'(dac_code), 512);
        check("R1", int'(sq_out), 0);
        rst = 1'b0;
        step();
        check("R1", int'(dac_code), 512);

        // R4 quadrant points with a zero accumulator, R6 two-edge delay
        tag = "R4";
        do_load(32'd0, 5'd8, 1'b0);
        step();
        check("R4", int'(dac_code), 1023);
        do_load(32'd0, 5'd16, 1'b0);
        step();
        check("R4", int'(dac_code), 511);
        check("R7", int'(sq_out), 1);
        do_load(32'd0, 5'd24, 1'b0);
        step();
        check("R4", int'(dac_code), 0);
        do_load(32'd0, 5'd0, 1'b0);
        run(2);

        // R2 frequency: square period 16 clocks
        tag = "R2";
        do_load(32'h1000_0000, 5'd0, 1'b0);
        run(3);
        rises = 0; prev = sq_out;
        for (int i = 0; i < 64; i++) begin
            step();
            if (sq_out && !prev) rises++;
            prev = sq_out;
        end
        check("R2", rises, 4);

        // R3 inputs without load are ignored
        tag = "R3";
        ftw_in = 32'h0123_4567; pow_in = 5'd13; pdn_in = 1'b1;
        run(20);

        // R5 sweep of the table with a slow, odd tuning word
        tag = "R5";
        do_load(32'h0013_5791, 5'd3, 1'b0);
        run(3000);

        // R6/R7 with moving phase word
        tag = "R6";
        for (int k = 0; k < 32; k++) begin
            do_load(32'h0270_0001 + 32'(k), 5'(k), 1'b0);
            run(5);
        end

        // R8 sleep: mid-scale, held phase, resume
        tag = "R8";
        do_load(32'h0100_0000, 5'd0, 1'b0);
        run(37);
        do_load(32'h0100_0000, 5'd0, 1'b1);
        step();
        check("R8", int'(dac_code), 512);
        check("R8", int'(sq_out), 0);
        held = m_acc;
        run(25);
        check("R8", int'(m_acc == held), 1);
        do_load(32'h0100_0000, 5'd0, 1'b0);
        run(40);

        // R9 wrap: backwards stepping
        tag = "R9";
        do_load(32'hFFFF_FFFF, 5'd0, 1'b0);
        run(50);
        do_load(32'hF000_0000, 5'd2, 1'b0);
        run(100);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule